// File: doc/BRIEF.md
# Ping-pong peripheral DMA channel

A single transfer channel that copies 32-bit words between a peripheral-side port and a memory-side port. Each word is one read on the source port followed by one write on the destination port. Both ports use a plain request/grant handshake, and read data is valid in the cycle of the grant. A selected peripheral request line can pace the transfers, or the channel can run freely. Software programs the channel through a small register bus with six word registers: control, status, a pointer and a sequence register for each side.

There are two ways to run the channel. In single-pass mode it moves word-count-plus-one words and then stops. In continuous mode the programmed buffer is split into two halves of word-count-plus-one words each. The channel raises its end-of-count flag at every half and flips a ping-pong status bit. After each full buffer it picks up freshly written pointers, so software can refill one half while the other is in flight. Each side can wrap its address inside a power-of-two window. Selecting request line 31 freezes the channel so that the remaining count can be read without a race.

Top module: `pdma_chan`

## Requirements
- R1: After reset every register reads zero, `irq` is low and neither port requests.
- R2: Register index on `rb_addr`: 0 control, 1 status, 2 peripheral pointer, 3 peripheral sequence, 4 memory pointer, 5 memory sequence. Read data appears on `rb_rdata` one cycle after the index. Control keeps only bits 31..27, 21 and 20:0 minus bits 1:0 (read mask 0xF83FFFFC). Pointers keep bits 31:2. The peripheral sequence keeps wrap bits 18:16. The memory sequence keeps wrap bits 18:16 and the double-buffer bit 19.
- R3: A 0-to-1 change of control bit 31 (enable) loads the remaining count from the word-count field (bits 15:2) and captures both pointers. Each word is one source read and then one destination write of the data read. Control bit 28 clear means peripheral to memory; set means memory to peripheral.
- R4: Single pass (control bit 27 set, or memory sequence bit 19 clear): word-count+1 words move, with word k of each side at start+4k. Then busy clears and the pending flag sets.
- R5: Continuous mode (control bit 27 clear and memory sequence bit 19 set): after every word-count+1 words the pending flag sets, the ping-pong bit toggles and the count reloads. Transfers continue until enable is cleared.
- R6: Pointer writes while the channel runs do not disturb the transfer in flight. In continuous mode they take effect once both halves are done, and the offset restarts at zero.
- R7: With control bit 21 (flow) set, a word starts only while `req_lines[sel]` is high, where sel is control bits 20:16. With bit 21 clear, words start back to back.
- R8: With select value 31, no word starts, the count holds, and status bit 29 (halted) reads 1 while busy. Selecting a valid line resumes the transfer without reloading the count.
- R9: Control bit 29 (hold) pauses new words and shows as halted. Clearing it resumes the transfer.
- R10: Wrap index i (sequence bits 18:16) makes the side address start+4*(k mod W). On the memory side W is 32·2^(i-1) words; on the peripheral side W is 2^(i-1) words. Index 0 means no wrap.
- R11: Status holds busy at bit 31, pending at 30, halted at 29, ping-pong at 28 and the remaining count at 15:2. A status write with bit 30 set clears pending. Any other status write has no effect.
- R12: `irq` is the registered AND of pending and control bit 30.
- R13: Clearing enable stops the channel within a cycle and drops busy. Pending, ping-pong and count keep their values, and no further words move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rb_wr | input | 1 | Register write strobe |
| rb_addr | input | 3 | Register index |
| rb_wdata | input | 32 | Register write data |
| rb_rdata | output | 32 | Registered read data |
| req_lines | input | 32 | Peripheral request lines (line 31 unused) |
| p_req | output | 1 | Peripheral port access request |
| p_we | output | 1 | Peripheral port write (else read) |
| p_addr | output | 32 | Peripheral port byte address |
| p_wdata | output | 32 | Peripheral port write data |
| p_gnt | input | 1 | Peripheral port grant |
| p_rdata | input | 32 | Peripheral port read data, valid with grant |
| m_req | output | 1 | Memory port access request |
| m_we | output | 1 | Memory port write (else read) |
| m_addr | output | 32 | Memory port byte address |
| m_wdata | output | 32 | Memory port write data |
| m_gnt | input | 1 | Memory port grant |
| m_rdata | input | 32 | Memory port read data, valid with grant |
| irq | output | 1 | End-of-count interrupt |

## Verification
The hardest state to reach is the buffer boundary in continuous mode. New pointers must be written while the second half is still running, and they must not appear until that half ends. The bench paces the channel through a flow-controlled request line that it raises for an exact number of destination writes and then drops. This parks the channel at each half boundary, where status is read and the pointers are rewritten before the next burst. Port grants are stalled on a fixed pattern, so every word also sees waits on both sides.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  // control register bit positions
  localparam int CB_EN     = 31;
  localparam int CB_IE     = 30;
  localparam int CB_HOLD   = 29;
  localparam int CB_DIR    = 28;
  localparam int CB_ONCE   = 27;
  localparam int CB_FLOW   = 21;
  localparam int CB_SEL_LO = 16;
  localparam int CB_CNT_LO = 2;
  // sequence register bit positions
  localparam int SB_DBL     = 19;
  localparam int SB_WRAP_LO = 16;
  // status register bit positions
  localparam int STB_BUSY = 31;
  localparam int STB_PEND = 30;
  localparam int STB_HALT = 29;
  localparam int STB_PING = 28;
  // register indices
  localparam logic [2:0] RI_CTRL = 3'd0;
  localparam logic [2:0] RI_STAT = 3'd1;
  localparam logic [2:0] RI_PPTR = 3'd2;
  localparam logic [2:0] RI_PSEQ = 3'd3;
  localparam logic [2:0] RI_MPTR = 3'd4;
  localparam logic [2:0] RI_MSEQ = 3'd5;

  typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_RD, ST_WR} xfer_st_t;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 5,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rb_wr,
  input  logic [2:0]       rb_addr,
  input  logic [31:0]      rb_wdata,
  output logic [31:0]      rb_rdata,
  input  logic             busy,
  input  logic             halted,
  input  logic             ping,
  input  logic [CNT_W-1:0] cnt,
  input  logic             term,
  output logic             en,
  output logic             ie,
  output logic             hold,
  output logic             dir,
  output logic             once,
  output logic             flow,
  output logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] wcount,
  output logic [AW-1:0]    pptr,
  output logic [AW-1:0]    mptr,
  output logic [2:0]       pwrap,
  output logic [2:0]       mwrap,
  output logic             dbl,
  output logic             pend,
  output logic             irq
);
  logic [AW-3:0] pptr_q, mptr_q;
  logic [31:0]   rd_mux;
  logic          clr_pend;

  assign pptr     = {pptr_q, 2'b00};
  assign mptr     = {mptr_q, 2'b00};
  assign clr_pend = rb_wr && (rb_addr == RI_STAT) && rb_wdata[STB_PEND];

  always_comb begin
    rd_mux = '0;
    case (rb_addr)
      RI_CTRL: begin
        rd_mux[CB_EN]   = en;
        rd_mux[CB_IE]   = ie;
        rd_mux[CB_HOLD] = hold;
        rd_mux[CB_DIR]  = dir;
        rd_mux[CB_ONCE] = once;
        rd_mux[CB_FLOW] = flow;
        rd_mux[CB_SEL_LO +: SEL_W] = sel;
        rd_mux[CB_CNT_LO +: CNT_W] = wcount;
      end
      RI_STAT: begin
        rd_mux[STB_BUSY] = busy;
        rd_mux[STB_PEND] = pend;
        rd_mux[STB_HALT] = halted;
        rd_mux[STB_PING] = ping;
        rd_mux[CB_CNT_LO +: CNT_W] = cnt;
      end
      RI_PPTR: rd_mux[AW-1:0] = pptr;
      RI_PSEQ: rd_mux[SB_WRAP_LO +: 3] = pwrap;
      RI_MPTR: rd_mux[AW-1:0] = mptr;
      RI_MSEQ: begin
        rd_mux[SB_WRAP_LO +: 3] = mwrap;
        rd_mux[SB_DBL] = dbl;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; ie <= 1'b0; hold <= 1'b0; dir <= 1'b0; once <= 1'b0;
      flow <= 1'b0; sel <= '0; wcount <= '0;
      pptr_q <= '0; mptr_q <= '0; pwrap <= '0; mwrap <= '0; dbl <= 1'b0;
      pend <= 1'b0; irq <= 1'b0; rb_rdata <= '0;
    end else begin
      if (rb_wr) begin
        case (rb_addr)
          RI_CTRL: begin
            en     <= rb_wdata[CB_EN];
            ie     <= rb_wdata[CB_IE];
            hold   <= rb_wdata[CB_HOLD];
            dir    <= rb_wdata[CB_DIR];
            once   <= rb_wdata[CB_ONCE];
            flow   <= rb_wdata[CB_FLOW];
            sel    <= rb_wdata[CB_SEL_LO +: SEL_W];
            wcount <= rb_wdata[CB_CNT_LO +: CNT_W];
          end
          RI_PPTR: pptr_q <= rb_wdata[AW-1:2];
          RI_PSEQ: pwrap  <= rb_wdata[SB_WRAP_LO +: 3];
          RI_MPTR: mptr_q <= rb_wdata[AW-1:2];
          RI_MSEQ: begin
            mwrap <= rb_wdata[SB_WRAP_LO +: 3];
            dbl   <= rb_wdata[SB_DBL];
          end
          default: ;
        endcase
      end
      if (term)          pend <= 1'b1;
      else if (clr_pend) pend <= 1'b0;
      irq      <= pend & ie;
      rb_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pdma_wrap.sv
module pdma_wrap #(
  parameter int AW    = 32,
  parameter int OFF_W = 14,
  parameter int SH    = 0
) (
  input  logic [AW-1:0]    base,
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       idx,
  output logic [AW-1:0]    addr
);
  logic [OFF_W-1:0] mask;
  int sh;

  always_comb begin
    sh   = int'(idx) - 1 + SH;
    mask = '1;
    if (idx != 3'd0 && sh < OFF_W) mask = (OFF_W'(1) << sh) - OFF_W'(1);
    addr = base + AW'({off & mask, 2'b00});
  end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 5,
  parameter int CNT_W = 14,
  parameter int OFF_W = 14,
  parameter int REQ_N = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hold,
  input  logic             dir,
  input  logic             cont,
  input  logic             flow,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] wcount,
  input  logic [AW-1:0]    pptr,
  input  logic [AW-1:0]    mptr,
  input  logic [REQ_N-1:0] req_lines,
  input  logic             p_gnt,
  input  logic [31:0]      p_rdata,
  input  logic             m_gnt,
  input  logic [31:0]      m_rdata,
  output logic             p_req,
  output logic             p_we,
  output logic             m_req,
  output logic             m_we,
  output logic [31:0]      wdata,
  output logic [AW-1:0]    pbase,
  output logic [AW-1:0]    mbase,
  output logic [OFF_W-1:0] off,
  output logic             busy,
  output logic             halted,
  output logic             ping,
  output logic [CNT_W-1:0] cnt,
  output logic             term
);
  localparam logic [SEL_W-1:0] SEL_NONE = '1;

  xfer_st_t st;
  logic en_q, go, src_gnt, dst_gnt;
  logic [31:0] src_data;

  assign src_gnt  = dir ? m_gnt : p_gnt;
  assign dst_gnt  = dir ? p_gnt : m_gnt;
  assign src_data = dir ? m_rdata : p_rdata;
  assign go       = !hold && (sel != SEL_NONE) && (!flow || req_lines[sel]);
  assign busy     = (st != ST_OFF);
  assign halted   = busy && (hold || sel == SEL_NONE);
  assign term     = en && en_q && (st == ST_WR) && dst_gnt && (cnt == '0);
  assign p_req    = ((st == ST_RD) && !dir) || ((st == ST_WR) && dir);
  assign m_req    = ((st == ST_RD) && dir) || ((st == ST_WR) && !dir);
  assign p_we     = (st == ST_WR);
  assign m_we     = (st == ST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OFF; en_q <= 1'b0; cnt <= '0; ping <= 1'b0; off <= '0;
      pbase <= '0; mbase <= '0; wdata <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        st <= ST_OFF;
      end else if (!en_q) begin
        st <= ST_WAIT; cnt <= wcount; ping <= 1'b0; off <= '0;
        pbase <= pptr; mbase <= mptr;
      end else begin
        case (st)
          ST_WAIT: if (go) st <= ST_RD;
          ST_RD: if (src_gnt) begin
            wdata <= src_data;
            st    <= ST_WR;
          end
          ST_WR: if (dst_gnt) begin
            off <= off + OFF_W'(1);
            if (cnt != '0) begin
              cnt <= cnt - CNT_W'(1);
              st  <= ST_WAIT;
            end else if (cont) begin
              cnt  <= wcount;
              ping <= ~ping;
              st   <= ST_WAIT;
              if (ping) begin
                off <= '0; pbase <= pptr; mbase <= mptr;
              end
            end else begin
              st <= ST_OFF;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SEL_W     = 5,
  parameter int MAX_BYTES = 65536,
  parameter int MEM_WSH   = 5,
  parameter int PER_WSH   = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rb_wr,
  input  logic [2:0]          rb_addr,
  input  logic [31:0]         rb_wdata,
  output logic [31:0]         rb_rdata,
  input  logic [(1<<SEL_W)-1:0] req_lines,
  output logic                p_req,
  output logic                p_we,
  output logic [AW-1:0]       p_addr,
  output logic [31:0]         p_wdata,
  input  logic                p_gnt,
  input  logic [31:0]         p_rdata,
  output logic                m_req,
  output logic                m_we,
  output logic [AW-1:0]       m_addr,
  output logic [31:0]         m_wdata,
  input  logic                m_gnt,
  input  logic [31:0]         m_rdata,
  output logic                irq
);
  localparam int OFF_W = $clog2(MAX_BYTES / 4);
  localparam int CNT_W = OFF_W;
  localparam int REQ_N = 1 << SEL_W;

  logic r_en, r_ie, r_hold, r_dir, r_once, r_flow, r_dbl, pend;
  logic [SEL_W-1:0] r_sel;
  logic [CNT_W-1:0] r_wcount, cnt;
  logic [AW-1:0] pptr, mptr, pbase, mbase;
  logic [2:0] pwrap, mwrap;
  logic [OFF_W-1:0] off;
  logic busy, halted, ping, term, cont;
  logic [31:0] wdata;

  assign cont    = !r_once && r_dbl;
  assign p_wdata = wdata;
  assign m_wdata = wdata;

  pdma_regs #(.AW(AW), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_rdata(rb_rdata), .busy(busy), .halted(halted), .ping(ping), .cnt(cnt),
    .term(term), .en(r_en), .ie(r_ie), .hold(r_hold), .dir(r_dir), .once(r_once),
    .flow(r_flow), .sel(r_sel), .wcount(r_wcount), .pptr(pptr), .mptr(mptr),
    .pwrap(pwrap), .mwrap(mwrap), .dbl(r_dbl), .pend(pend), .irq(irq)
  );

  pdma_engine #(.AW(AW), .SEL_W(SEL_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .REQ_N(REQ_N)) u_eng (
    .clk(clk), .rst(rst), .en(r_en), .hold(r_hold), .dir(r_dir), .cont(cont),
    .flow(r_flow), .sel(r_sel), .wcount(r_wcount), .pptr(pptr), .mptr(mptr),
    .req_lines(req_lines), .p_gnt(p_gnt), .p_rdata(p_rdata), .m_gnt(m_gnt),
    .m_rdata(m_rdata), .p_req(p_req), .p_we(p_we), .m_req(m_req), .m_we(m_we),
    .wdata(wdata), .pbase(pbase), .mbase(mbase), .off(off), .busy(busy),
    .halted(halted), .ping(ping), .cnt(cnt), .term(term)
  );

  for (genvar g = 0; g < 2; g++) begin : g_side
    if (g == 0) begin : g_per
      pdma_wrap #(.AW(AW), .OFF_W(OFF_W), .SH(PER_WSH)) u_wrap (
        .base(pbase), .off(off), .idx(pwrap), .addr(p_addr));
    end else begin : g_mem
      pdma_wrap #(.AW(AW), .OFF_W(OFF_W), .SH(MEM_WSH)) u_wrap (
        .base(mbase), .off(off), .idx(mwrap), .addr(m_addr));
    end
  end
endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             hold,
  input logic [SEL_W-1:0] sel,
  input logic             cont,
  input logic             term,
  input logic             busy,
  input logic             ping,
  input logic             pend,
  input logic             p_req,
  input logic             m_req,
  input logic             rb_wr,
  input logic [2:0]       rb_addr,
  input logic [31:0]      rb_wdata
);
  logic idle_ports, pend_clr;
  assign idle_ports = !p_req && !m_req;
  assign pend_clr   = rb_wr && (rb_addr == 3'd1) && rb_wdata[30];

  // R3: one access at a time
  p_one_port_r3: assert property (@(posedge clk) disable iff (rst) !(p_req && m_req));
  // R4: single pass stops after terminal count
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (term && !cont) |=> !busy);
  // R5: each half flips ping-pong
  p_ping_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (term && cont) |=> (ping != $past(ping)));
  // R8: invalid select starts nothing
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (en && sel == '1 && idle_ports) |=> idle_ports);
  // R9: hold starts nothing
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (en && hold && idle_ports) |=> idle_ports);
  // R11: status write with bit 30 clears pending
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (pend_clr && !term) |=> !pend);
  // R13: pending survives anything but a clearing write
  p_pend_keep_r13: assert property (@(posedge clk) disable iff (rst)
    (pend && !pend_clr) |=> pend);
  // R13: disable drops busy
  p_disable_r13: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);
endmodule

bind pdma_chan pdma_chan_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .en(r_en), .hold(r_hold), .sel(r_sel), .cont(cont),
  .term(term), .busy(busy), .ping(ping), .pend(pend), .p_req(p_req),
  .m_req(m_req), .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_wdata(rb_wdata)
);

// File: tb/sim_pdma_chan.sv
`timescale 1ns/1ps
module sim_pdma_chan;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rb_wr = 1'b0;
  logic [2:0] rb_addr = '0;
  logic [31:0] rb_wdata = '0;
  logic [31:0] rb_rdata;
  logic [31:0] req_lines = '0;
  logic p_req, p_we, p_gnt, m_req, m_we, m_gnt, irq;
  logic [31:0] p_addr, p_wdata, p_rdata, m_addr, m_wdata, m_rdata;

  logic [31:0] mem_a [0:4095];
  logic [31:0] per_a [0:255];
  logic [2:0] stall_c = 3'd0;

  int n_chk = 0, n_err = 0, n_acc = 0, cyc = 0;

  typedef struct { logic [31:0] da; logic [31:0] sa; logic to_mem; int tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pdma_chan u0 (
    .clk(clk), .rst(rst), .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_rdata(rb_rdata), .req_lines(req_lines), .p_req(p_req), .p_we(p_we),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_gnt(p_gnt), .p_rdata(p_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_gnt(m_gnt), .m_rdata(m_rdata), .irq(irq)
  );

  assign p_gnt   = p_req && (stall_c != 3'd5);
  assign m_gnt   = m_req && (stall_c != 3'd2);
  assign p_rdata = per_a[p_addr[9:2]];
  assign m_rdata = mem_a[m_addr[13:2]];

  always @(posedge clk) stall_c <= stall_c + 3'd1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: every destination write is compared with the next expected word
  task automatic take_write(input logic [31:0] a, input logic [31:0] d, input logic to_mem);
    exp_t e;
    logic [31:0] ed;
    if (q.size() == 0) begin
      chk(1'b0, "R13/R8 unexpected destination write", a, 32'h0);
      return;
    end
    e  = q.pop_front();
    ed = e.to_mem ? per_a[e.sa[9:2]] : mem_a[e.sa[13:2]];
    n_chk++;
    if (e.da !== a || ed !== d || e.to_mem !== to_mem) begin
      n_err++;
      $display("FAIL R%0d write addr=%h data=%h expected addr=%h data=%h", e.tag, a, d, e.da, ed);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_req && m_we && m_gnt) begin
      take_write(m_addr, m_wdata, 1'b1);
      mem_a[m_addr[13:2]] = m_wdata;
      n_acc++;
    end
    if (!rst && p_req && p_we && p_gnt) begin
      take_write(p_addr, p_wdata, 1'b0);
      per_a[p_addr[9:2]] = p_wdata;
      n_acc++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [31:0] ctl(input bit en, ie, hold, dir, once, flow,
                                      input logic [4:0] sel, input logic [13:0] wc);
    return {en, ie, hold, dir, once, 5'b0, flow, sel, wc, 2'b00};
  endfunction

  task automatic rwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); rb_wr = 1'b1; rb_addr = a; rb_wdata = d;
    @(negedge clk); rb_wr = 1'b0;
  endtask

  task automatic rrd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rb_wr = 1'b0; rb_addr = a;
    @(negedge clk); d = rb_rdata;
  endtask

  task automatic push_run(input bit dir, input logic [31:0] pb, input int pw,
                          input logic [31:0] mb, input int mw, input int k0,
                          input int n, input int tag);
    for (int k = k0; k < k0 + n; k++) begin
      exp_t e;
      logic [31:0] pa, ma;
      pa = pb + 32'(4 * ((pw == 0) ? k : k % pw));
      ma = mb + 32'(4 * ((mw == 0) ? k : k % mw));
      e.to_mem = !dir;
      e.da = dir ? pa : ma;
      e.sa = dir ? ma : pa;
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rrd(3'd1, s);
      if (!s[31]) return;
    end
  endtask

  task automatic run_words(input int line, input int n);
    int target;
    target = n_acc + n;
    @(negedge clk); req_lines[line] = 1'b1;
    while (n_acc < target) begin
      @(negedge clk); #1;
    end
    req_lines[line] = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    for (int i = 0; i < 4096; i++) mem_a[i] = 32'h5000_0000 | 32'(i * 7);
    for (int i = 0; i < 256; i++)  per_a[i] = 32'hA000_0000 | 32'(i * 13);
    idle_cycles(3);
    rst = 1'b0;

    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      rrd(3'(r), v);
      chk(v == 32'h0, "R1 register after reset", v, 32'h0);
    end
    chk(irq == 1'b0 && p_req == 1'b0 && m_req == 1'b0, "R1 outputs idle", {p_req, m_req, irq}, 0);

    // R2 field storage
    rwr(3'd0, 32'h7FFF_FFFF); rrd(3'd0, v); chk(v == 32'h783F_FFFC, "R2 control mask", v, 32'h783F_FFFC);
    rwr(3'd2, 32'hFFFF_FFFF); rrd(3'd2, v); chk(v == 32'hFFFF_FFFC, "R2 pointer mask", v, 32'hFFFF_FFFC);
    rwr(3'd3, 32'hFFFF_FFFF); rrd(3'd3, v); chk(v == 32'h0007_0000, "R2 peripheral sequence", v, 32'h0007_0000);
    rwr(3'd5, 32'hFFFF_FFFF); rrd(3'd5, v); chk(v == 32'h000F_0000, "R2 memory sequence", v, 32'h000F_0000);
    rwr(3'd0, 0); rwr(3'd3, 0); rwr(3'd5, 0);

    // R3 R4 R12 R11: single pass, peripheral to memory, free running
    rwr(3'd2, 32'h40); rwr(3'd4, 32'h100);
    rwr(3'd0, ctl(0, 1, 0, 0, 1, 0, 5'd0, 14'd7));
    push_run(0, 32'h40, 0, 32'h100, 0, 0, 8, 4);
    rwr(3'd0, ctl(1, 1, 0, 0, 1, 0, 5'd0, 14'd7));
    wait_idle();
    rrd(3'd1, v); chk(v == 32'h4000_0000, "R4 status after single pass", v, 32'h4000_0000);
    chk(irq == 1'b1, "R12 irq with enable", irq, 1);
    rwr(3'd1, 32'hBFFF_FFFF); rrd(3'd1, v);
    chk(v == 32'h4000_0000, "R11 write without bit 30 ignored", v, 32'h4000_0000);
    rwr(3'd1, 32'h4000_0000); rrd(3'd1, v);
    chk(v == 32'h0, "R11 pending cleared", v, 0);
    idle_cycles(2); chk(irq == 1'b0, "R12 irq drops", irq, 0);
    rwr(3'd0, 0);

    // R8 R7 R10: memory to peripheral, flow paced, peripheral wrap of 2 words
    req_lines = 32'h7FFF_FFFF;
    rwr(3'd2, 32'h20); rwr(3'd3, 32'h0002_0000); rwr(3'd4, 32'h800);
    rwr(3'd0, ctl(1, 0, 0, 1, 1, 1, 5'd31, 14'd5));
    idle_cycles(20);
    rrd(3'd1, v); chk(v == 32'hA000_0014, "R8 frozen with select 31", v, 32'hA000_0014);
    req_lines = 0;
    push_run(1, 32'h20, 2, 32'h800, 0, 0, 6, 10);
    rwr(3'd0, ctl(1, 0, 0, 1, 1, 1, 5'd3, 14'd5));
    run_words(3, 2);
    idle_cycles(3);
    rrd(3'd1, v); chk(v == 32'h8000_000C, "R7 count after two paced words", v, 32'h8000_000C);
    req_lines[7] = 1'b1;
    idle_cycles(10);
    rrd(3'd1, v); chk(v == 32'h8000_000C, "R7 other line ignored", v, 32'h8000_000C);
    req_lines = 0;
    run_words(3, 4);
    wait_idle();
    rrd(3'd1, v); chk(v == 32'h4000_0000, "R4 done after paced run", v, 32'h4000_0000);
    chk(irq == 1'b0, "R12 no irq without enable bit", irq, 0);
    rwr(3'd1, 32'h4000_0000); rwr(3'd0, 0); rwr(3'd3, 0);

    // R10: memory wrap of 32 words, 40 words moved
    rwr(3'd2, 32'h0); rwr(3'd4, 32'h400); rwr(3'd5, 32'h0001_0000);
    push_run(0, 32'h0, 0, 32'h400, 32, 0, 40, 10);
    rwr(3'd0, ctl(1, 0, 0, 0, 1, 0, 5'd0, 14'd39));
    wait_idle();
    chk(q.size() == 0, "R10 all wrapped words written", 32'(q.size()), 0);
    rwr(3'd1, 32'h4000_0000); rwr(3'd0, 0); rwr(3'd5, 0);

    // R9 hold
    rwr(3'd2, 32'h80); rwr(3'd4, 32'hC00);
    rwr(3'd0, ctl(1, 0, 1, 0, 1, 0, 5'd0, 14'd2));
    idle_cycles(10);
    rrd(3'd1, v); chk(v == 32'hA000_0008, "R9 held channel", v, 32'hA000_0008);
    push_run(0, 32'h80, 0, 32'hC00, 0, 0, 3, 9);
    rwr(3'd0, ctl(1, 0, 0, 0, 1, 0, 5'd0, 14'd2));
    wait_idle();
    chk(q.size() == 0, "R9 resumed after hold", 32'(q.size()), 0);
    rwr(3'd1, 32'h4000_0000); rwr(3'd0, 0);

    // R5 R6 R13: continuous ping-pong, peripheral to memory, paced by line 9
    rwr(3'd2, 32'h100); rwr(3'd4, 32'h1000); rwr(3'd5, 32'h0008_0000);
    rwr(3'd0, ctl(1, 1, 0, 0, 0, 1, 5'd9, 14'd3));
    push_run(0, 32'h100, 0, 32'h1000, 0, 0, 4, 5);
    run_words(9, 4);
    idle_cycles(3);
    rrd(3'd1, v); chk(v == 32'hD000_000C, "R5 first half done", v, 32'hD000_000C);
    chk(irq == 1'b1, "R12 irq at half", irq, 1);
    rwr(3'd1, 32'h4000_0000);
    rwr(3'd4, 32'h1800); rwr(3'd2, 32'h180);
    push_run(0, 32'h100, 0, 32'h1000, 0, 4, 4, 6);
    run_words(9, 4);
    idle_cycles(3);
    rrd(3'd1, v); chk(v == 32'hC000_000C, "R5 second half done", v, 32'hC000_000C);
    rwr(3'd1, 32'h4000_0000);
    push_run(0, 32'h180, 0, 32'h1800, 0, 0, 4, 6);
    run_words(9, 4);
    idle_cycles(3);
    chk(q.size() == 0, "R6 new pointers used after boundary", 32'(q.size()), 0);
    rwr(3'd0, ctl(0, 1, 0, 0, 0, 1, 5'd9, 14'd3));
    rrd(3'd1, v); chk(v == 32'h5000_000C, "R13 disabled keeps pending", v, 32'h5000_000C);
    req_lines[9] = 1'b1;
    idle_cycles(12);
    req_lines[9] = 1'b0;
    chk(p_req == 1'b0 && m_req == 1'b0, "R13 no traffic after disable", {p_req, m_req}, 0);
    rwr(3'd1, 32'h4000_0000);

    chk(q.size() == 0, "R3 model queue drained", 32'(q.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule